// File: doc/BRIEF.md
# DMA Bus Tenure Limiter

This block decides how long a burst-mode DMA engine may hold the system bus once it has been granted. It raises a bus request when the engine reports pending work. While the grant is held it counts granted clock cycles and completed bus transactions. Each of the two counts can be compared against its own limit, and a limit value of zero switches that limit off. When an enabled limit is reached, the block raises a must-release indication. This tells the engine to start no new transfer. Any transfer already in flight is allowed to finish. After that the block drops the request and holds it low for a programmable back-off time before asking again.

The limits act only when burst operation is selected. If both limits are enabled, the tenure ends at whichever limit is reached first. The counters restart at every new grant. They stand still in any cycle of a tenure in which the arbiter has withdrawn the grant, so a withdrawn grant does not consume budget. The engine may also end a tenure early by clearing its pending-work flag, and that path releases the bus with no back-off.

Top module: `dma_tenure_limiter`

## Requirements
- R1: While reset is active, and in the first cycle after reset, `bus_req` and `must_release` are both 0.
- R2: With the block idle and `work_pending` sampled high at a clock edge, `bus_req` is 1 after that edge. With `work_pending` low, `bus_req` stays 0.
- R3: With only the cycle limit N set (N > 0, `txn_limit` = 0, `burst_en` = 1), `must_release` rises after exactly N rising clock edges at which the block owns the bus and `bus_grant` is 1. Counting starts fresh at each new grant.
- R4: With only the transaction limit M set (M > 0), `must_release` is 1 in the cycle after the M-th `xfer_done` pulse of the tenure is sampled. A pulse on every clock is counted.
- R5: With both limits set, `must_release` rises at whichever limit is reached first.
- R6: A limit value of 0 disables that limit. With both limits 0, `must_release` never rises.
- R7: With `burst_en` = 0, `must_release` never rises, whatever the limits are.
- R8: A clock edge at which `bus_grant` is 0 during a tenure does not advance the cycle count. `bus_req` stays 1 through such cycles.
- R9: While `must_release` is 1 and `xfer_busy` is 1, `bus_req` and `must_release` stay 1. At the first edge with `must_release` = 1 and `xfer_busy` = 0, `bus_req` falls.
- R10: After a limit release, `bus_req` stays 0 for max(`backoff_len`, 1) cycles. It is then reasserted if `work_pending` is 1, and otherwise stays 0.
- R11: During a tenure, `work_pending` = 0 with `xfer_busy` = 0 at a clock edge drops `bus_req` after that edge, with no back-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_en | input | 1 | 1 = burst operation, limits active |
| cyc_limit | input | CYC_W | Granted-cycle budget per tenure, 0 = off |
| txn_limit | input | TXN_W | Transaction budget per tenure, 0 = off |
| backoff_len | input | GAP_W | Request-low cycles after a limit release (0 acts as 1) |
| work_pending | input | 1 | DMA engine has transfers to do |
| bus_grant | input | 1 | Bus arbiter grant |
| xfer_busy | input | 1 | A bus transfer is in flight |
| xfer_done | input | 1 | One-cycle pulse per completed transfer |
| bus_req | output | 1 | Bus request to the arbiter |
| must_release | output | 1 | Engine must start no new transfer |

## Verification
A wrong count shows at the ports as a `must_release` edge that comes one or more cycles early or late against the granted-cycle or transaction budget. It therefore appears within a single tenure, and the bench measures the tenure length exactly under several limit combinations. A wrong controller state shows as a request that does not fall after the in-flight transfer ends, a back-off with the wrong number of low cycles, or a request that does not return. Each of these is visible within one back-off period of the release.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
   typedef enum logic [1:0] {
      TS_IDLE = 2'd0,
      TS_REQ  = 2'd1,
      TS_OWN  = 2'd2,
      TS_GAP  = 2'd3
   } tenure_state_e;
endpackage

// File: rtl/tenure_count.sv
module tenure_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic         hit
);
   localparam logic [W-1:0] CMAX = '1;

   if (W < 1) begin : g_bad_w
      $error("tenure_count: W must be at least 1");
   end

   logic [W-1:0] count;

   // saturating up-counter, cleared at the start of a tenure
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    count <= '0;
      else if (clear)                count <= '0;
      else if (inc && count != CMAX) count <= count + 1'b1;
   end

   assign hit = (limit != '0) && (count >= limit);

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !inc) |=> $stable(count)); // R8
endmodule

// File: rtl/backoff_timer.sv
module backoff_timer #(
   parameter int GAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [GAP_W-1:0] len,
   output logic             last
);
   if (GAP_W < 1) begin : g_bad_gw
      $error("backoff_timer: GAP_W must be at least 1");
   end

   logic [GAP_W-1:0] remain;
   logic [GAP_W-1:0] eff_len;

   // a zero length still holds the request low for one cycle
   assign eff_len = (len == '0) ? GAP_W'(1) : len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (load)           remain <= eff_len;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign last = (remain == GAP_W'(1));

   AST_GAP_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && remain > GAP_W'(1)) |=> (remain == $past(remain) - 1'b1)); // R10
endmodule

// File: rtl/tenure_fsm.sv
module tenure_fsm
   import tenure_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic work_pending,
   input  logic bus_grant,
   input  logic xfer_busy,
   input  logic limit_hit,
   input  logic gap_last,
   output logic own_now,
   output logic start_tenure,
   output logic start_gap,
   output logic bus_req,
   output logic must_release
);
   tenure_state_e state, state_nx;

   assign own_now      = (state == TS_OWN);
   assign must_release = own_now && limit_hit;
   assign start_tenure = (state == TS_REQ) && bus_grant;
   assign start_gap    = must_release && !xfer_busy;
   assign bus_req      = (state == TS_REQ) || (state == TS_OWN);

   always_comb begin
      state_nx = state;
      unique case (state)
         TS_IDLE: if (work_pending) state_nx = TS_REQ;
         TS_REQ: begin
            if (bus_grant)          state_nx = TS_OWN;
            else if (!work_pending) state_nx = TS_IDLE;
         end
         TS_OWN: begin
            if (start_gap)                         state_nx = TS_GAP;
            else if (!work_pending && !xfer_busy)  state_nx = TS_IDLE;
         end
         TS_GAP: if (gap_last) state_nx = work_pending ? TS_REQ : TS_IDLE;
         default: state_nx = TS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= TS_IDLE;
      else        state <= state_nx;
   end

   AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (must_release && xfer_busy) |=> (bus_req && must_release)); // R9
   AST_DRAIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (must_release && !xfer_busy) |=> !bus_req); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TS_IDLE && !work_pending) |=> !bus_req); // R2
   AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (own_now && !bus_grant && !must_release && work_pending) |=> bus_req); // R8
endmodule

// File: rtl/dma_tenure_limiter.sv
module dma_tenure_limiter #(
   parameter int CYC_W         = 12,
   parameter int TXN_W         = 8,
   parameter int GAP_W         = 8,
   parameter bit USE_TXN_LIMIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             burst_en,
   input  logic [CYC_W-1:0] cyc_limit,
   input  logic [TXN_W-1:0] txn_limit,
   input  logic [GAP_W-1:0] backoff_len,
   input  logic             work_pending,
   input  logic             bus_grant,
   input  logic             xfer_busy,
   input  logic             xfer_done,
   output logic             bus_req,
   output logic             must_release
);
   if (CYC_W < 2 || CYC_W > 32) begin : g_bad_cyc
      $error("dma_tenure_limiter: CYC_W out of range 2..32");
   end
   if (TXN_W < 1 || TXN_W > 32) begin : g_bad_txn
      $error("dma_tenure_limiter: TXN_W out of range 1..32");
   end

   logic own_now, start_tenure, start_gap, gap_last;
   logic cyc_hit, txn_hit, limit_hit;

   tenure_count #(.W(CYC_W)) u_cyc (
      .clk(clk), .rst_n(rst_n), .clear(start_tenure),
      .inc(own_now && bus_grant), .limit(cyc_limit), .hit(cyc_hit));

   if (USE_TXN_LIMIT) begin : g_txn
      tenure_count #(.W(TXN_W)) u_txn (
         .clk(clk), .rst_n(rst_n), .clear(start_tenure),
         .inc(own_now && xfer_done), .limit(txn_limit), .hit(txn_hit));
   end else begin : g_no_txn
      assign txn_hit = 1'b0;
   end

   // either enabled budget ends the tenure, only in burst operation
   assign limit_hit = burst_en && (cyc_hit || txn_hit);

   backoff_timer #(.GAP_W(GAP_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .load(start_gap),
      .len(backoff_len), .last(gap_last));

   tenure_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .work_pending(work_pending),
      .bus_grant(bus_grant), .xfer_busy(xfer_busy), .limit_hit(limit_hit),
      .gap_last(gap_last), .own_now(own_now), .start_tenure(start_tenure),
      .start_gap(start_gap), .bus_req(bus_req), .must_release(must_release));

   AST_MR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      must_release |-> bus_req); // R3
   AST_NO_MR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_en && $stable(burst_en)) |=> !must_release); // R7
   AST_ZERO_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_limit == '0 && txn_limit == '0 && $stable(cyc_limit) && $stable(txn_limit))
      |=> !must_release); // R6
endmodule

// File: tb/sim_dma_tenure_limiter.sv
module sim_dma_tenure_limiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        burst_en = 1'b1;
   logic [11:0] cyc_limit = '0;
   logic [7:0]  txn_limit = '0;
   logic [7:0]  backoff_len = '0;
   logic        work_pending = 1'b0, bus_grant = 1'b0, xfer_busy = 1'b0, xfer_done = 1'b0;
   logic        bus_req, must_release;

   int n_chk = 0, n_err = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   dma_tenure_limiter u0 (
      .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .cyc_limit(cyc_limit),
      .txn_limit(txn_limit), .backoff_len(backoff_len), .work_pending(work_pending),
      .bus_grant(bus_grant), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
      .bus_req(bus_req), .must_release(must_release));

   // burst, cyc_limit, txn_limit, backoff, done period, expected tenure, expected gap
   // expected tenure 60 means no release seen within the 60-cycle cap
   localparam int NV = 8;
   localparam int VEC [NV][7] = '{
      '{1,  5, 0, 3, 0,  5, 3},
      '{1,  0, 2, 2, 3,  6, 2},
      '{1,  4, 3, 1, 2,  4, 1},
      '{1, 20, 2, 4, 3,  6, 4},
      '{1,  0, 0, 2, 2, 60, 0},
      '{0,  3, 1, 2, 2, 60, 0},
      '{1,  1, 0, 0, 0,  1, 1},
      '{1,  0, 1, 5, 3,  3, 5}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_req();
      for (int g = 0; g < 10; g++) begin
         @(negedge clk);
         if (bus_req) break;
      end
   endtask

   function automatic string tag_of(input int v);
      if (VEC[v][0] == 0)                     return "R7 single mode";
      if (VEC[v][1] != 0 && VEC[v][2] != 0)   return "R5 first limit";
      if (VEC[v][1] != 0)                     return "R3 cycle limit";
      if (VEC[v][2] != 0)                     return "R4 txn limit";
      return "R6 both off";
   endfunction

   task automatic run_vec(input int v);
      int own = 0, gap = 0, per;
      bit seen = 1'b0;
      per          = VEC[v][4];
      burst_en     = VEC[v][0] != 0;
      cyc_limit    = 12'(VEC[v][1]);
      txn_limit    = 8'(VEC[v][2]);
      backoff_len  = 8'(VEC[v][3]);
      work_pending = 1'b1;
      wait_req();
      bus_grant = 1'b1;
      for (int g = 0; g < 80; g++) begin
         @(negedge clk);
         if (must_release) begin seen = 1'b1; break; end
         own++;
         if (own >= 60) break;
         xfer_done = (per != 0) && (own % per == 0);
      end
      xfer_done = 1'b0;
      chk(own == VEC[v][5], tag_of(v), own, VEC[v][5]);
      if (seen) begin
         for (int g = 0; g < 40; g++) begin
            @(negedge clk);
            if (bus_req) break;
            gap++;
            bus_grant = 1'b0;
         end
         chk(gap == VEC[v][6], "R10 backoff length", gap, VEC[v][6]);
         work_pending = 1'b0;
         bus_grant    = 1'b0;
         @(negedge clk);
      end else begin
         work_pending = 1'b0;
         @(negedge clk);
         chk(!bus_req && !must_release, "R11 voluntary release", bus_req, 0);
         bus_grant = 1'b0;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!bus_req && !must_release, "R1 in reset", {bus_req, must_release}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bus_req && !must_release, "R1 after reset", {bus_req, must_release}, 0);
      repeat (3) @(negedge clk);
      chk(!bus_req, "R2 no work no request", bus_req, 0);
      work_pending = 1'b1;
      @(negedge clk);
      chk(bus_req, "R2 request after work", bus_req, 1);
      work_pending = 1'b0;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++) run_vec(v);

      // R8: withdrawn grant holds the cycle count, request stays up
      begin
         int own = 0;
         bit hold_ok = 1'b1;
         burst_en = 1'b1; cyc_limit = 12'd4; txn_limit = 8'd0; backoff_len = 8'd1;
         work_pending = 1'b1;
         wait_req();
         bus_grant = 1'b1;
         for (int s = 1; s < 40; s++) begin
            @(negedge clk);
            if (must_release) break;
            if (!bus_req) hold_ok = 1'b0;
            bus_grant = !(s >= 3 && s <= 7);
            if (bus_grant) own++;
         end
         chk(hold_ok, "R8 request held without grant", hold_ok, 1);
         chk(own == 4, "R8 granted cycles counted", own, 4);
         work_pending = 1'b0; bus_grant = 1'b0;
         repeat (6) @(negedge clk);
      end

      // R9 drain, then R10 with work withdrawn during back-off
      begin
         int own = 0, gap = 1;
         bit low_ok = 1'b1;
         cyc_limit = 12'd2; backoff_len = 8'd2;
         work_pending = 1'b1; xfer_busy = 1'b1;
         wait_req();
         bus_grant = 1'b1;
         for (int g = 0; g < 40; g++) begin
            @(negedge clk);
            if (must_release) break;
            own++;
         end
         chk(own == 2, "R3 limit under busy transfer", own, 2);
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(bus_req && must_release, "R9 hold while busy", {bus_req, must_release}, 3);
         end
         xfer_busy = 1'b0;
         @(negedge clk);
         chk(!bus_req, "R9 drop after transfer ends", bus_req, 0);
         bus_grant = 1'b0;
         work_pending = 1'b0;
         for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (bus_req) low_ok = 1'b0;
         end
         chk(low_ok && gap == 1, "R10 no request after back-off without work", bus_req, 0);
      end

      // R1: reset in the middle of a tenure
      cyc_limit = 12'd0;
      work_pending = 1'b1;
      wait_req();
      bus_grant = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!bus_req && !must_release, "R1 reset during tenure", bus_req, 0);
      work_pending = 1'b0; bus_grant = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule